// File: doc/BRIEF.md
# Grouped MSI Interrupt Controller

This block gathers message-signalled interrupts and presents them to a host processor as eight interrupt lines. A vector number arrives either as a register write to a doorbell address on the 32-bit register bus or as a message on a separate inbound port from the link side. Each vector `v` below 32 is recorded as a pending bit in group `v mod 8`, at bit position `v / 8`. Each group therefore holds four pending bits, and group `g` bit `s` stands for vector `g + 8*s`.

Each group has a pending-status register, an enable-set register and an enable-clear register. A group drives its own level-sensitive interrupt line whenever one of its pending bits is also enabled. The end-of-interrupt register is shared with other interrupt sources outside this block. A write of `g + 4` to it acknowledges group `g`, and the line drops for one cycle before it is evaluated again. Software thus sees a fresh assertion for every vector still pending. Bus reads are combinational on the address.

Top module: `msi_group_ctrl`

## Requirements
- R1: After reset every pending bit, every enable bit and every interrupt line is 0.
- R2: A doorbell value v below 32, written to bus offset 0x054 or presented on the message port, sets bit v/8 of the status register of group v mod 8. Group g's status register is at offset 0x104 + 16*g.
- R3: A doorbell value of 32 or more, on either path, changes no pending bit.
- R4: Writing the status register clears each pending bit whose data bit is 1. Bits written 0 keep their value.
- R5: Writing 1s to the enable-set register (0x108 + 16*g) enables those vectors. Writing 1s to the enable-clear register (0x10C + 16*g) disables them. A read of either register returns the group's current 4-bit enable mask.
- R6: A status read returns the raw pending bits whatever the enable mask holds.
- R7: `irq_o[g]` is a register. It is 1 in the cycle after a cycle in which group g has a pending bit that is also enabled, unless R8 applies.
- R8: A bus write of g + 4 to offset 0x050 forces `irq_o[g]` to 0 for the next cycle. The line is then evaluated again and returns to 1 if enabled bits are still pending.
- R9: End-of-interrupt codes below 4, or of 12 and above, leave every line unchanged. A code for one group leaves the other groups' lines unchanged.
- R10: A doorbell arriving in the same cycle as a status clear of the same bit leaves that bit set. A clear of a different bit in that cycle still takes effect.
- R11: Data bits 4 to 31 of the group registers read 0 and are ignored on writes. Addresses outside the register set read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| msg_valid | input | 1 | Inbound interrupt message strobe |
| msg_data | input | 32 | Vector number carried by the message |
| irq_o | output | 8 | One interrupt line per group |

## Verification
The hardest situation to reach is a doorbell and a status clear that hit the same bit in the same cycle. A single register bus cannot issue both at once. The bench therefore drives the message port and a bus write to the status register on the same clock edge, once for the same bit and once for a neighbouring bit. The other delicate case is the one-cycle low pulse after an acknowledge while enabled bits remain pending. The bench samples the line at the negative edge just after the acknowledge edge and again one cycle later. All 32 vectors are swept over both doorbell paths against an arithmetic model of the group and bit placement.

// File: rtl/msi_grp_pkg.sv
package msi_grp_pkg;

   // Byte offsets the host software relies on
   localparam int OFS_EOI      = 'h050;
   localparam int OFS_DOORBELL = 'h054;
   localparam int OFS_GRP_BASE = 'h100;
   localparam int GRP_STRIDE   = 16;
   localparam int EOI_BASE     = 4;

   // Register within a group window, taken from address bits [3:2]
   typedef enum logic [1:0] {
      KIND_NONE = 2'd0,
      KIND_STAT = 2'd1,
      KIND_ESET = 2'd2,
      KIND_ECLR = 2'd3
   } grp_reg_e;

endpackage

// File: rtl/msi_grp_decode.sv
module msi_grp_decode
   import msi_grp_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int NUM_GRP = 8,
   localparam int GIDX_W = $clog2(NUM_GRP)
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              is_doorbell,
   output logic [NUM_GRP-1:0] eoi_oh,
   output logic [GIDX_W-1:0] grp_idx,
   output grp_reg_e          grp_kind
);

   logic              wr_ok;
   logic              is_eoi;
   logic              in_win;
   logic [ADDR_W-1:0] rel;

   assign wr_ok       = sel & wr;
   assign is_doorbell = (addr == ADDR_W'(OFS_DOORBELL));
   assign is_eoi      = (addr == ADDR_W'(OFS_EOI));
   assign rel         = addr - ADDR_W'(OFS_GRP_BASE);

   always_comb begin
      in_win  = 1'b0;
      grp_idx = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (addr >= ADDR_W'(OFS_GRP_BASE) && rel[ADDR_W-1:4] == (ADDR_W-4)'(g)) begin
            in_win  = 1'b1;
            grp_idx = GIDX_W'(g);
         end
      end
      grp_kind = KIND_NONE;
      if (in_win && rel[1:0] == 2'b00)
         grp_kind = grp_reg_e'(rel[3:2]);
   end

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_eoi
      assign eoi_oh[g] = wr_ok & is_eoi & (wdata == DATA_W'(EOI_BASE + g));
   end

endmodule

// File: rtl/msi_grp_vecdec.sv
module msi_grp_vecdec #(
   parameter int DATA_W = 32,
   parameter int NUM_GRP = 8,
   parameter int GRP_BITS = 4,
   localparam int NUM_VEC = NUM_GRP * GRP_BITS
) (
   input  logic               valid,
   input  logic [DATA_W-1:0]  vec,
   output logic [NUM_VEC-1:0] set_flat
);

   // Vector i lands in group (i mod NUM_GRP), bit (i / NUM_GRP)
   always_comb begin
      set_flat = '0;
      for (int i = 0; i < NUM_VEC; i++) begin
         if (valid && vec == DATA_W'(i))
            set_flat[(i % NUM_GRP) * GRP_BITS + (i / NUM_GRP)] = 1'b1;
      end
   end

endmodule

// File: rtl/msi_grp_bank.sv
module msi_grp_bank #(
   parameter int GRP_BITS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [GRP_BITS-1:0] set_i,
   input  logic                st_wr_i,
   input  logic                es_wr_i,
   input  logic                ec_wr_i,
   input  logic [GRP_BITS-1:0] wmask_i,
   input  logic                eoi_i,
   output logic [GRP_BITS-1:0] pend_o,
   output logic [GRP_BITS-1:0] en_o,
   output logic                irq_o
);

   logic [GRP_BITS-1:0] pend_q;
   logic [GRP_BITS-1:0] en_q;
   logic                irq_q;
   logic [GRP_BITS-1:0] clr_mask;

   assign clr_mask = st_wr_i ? wmask_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         en_q   <= '0;
         irq_q  <= 1'b0;
      end else begin
         // arriving vectors win over a clear of the same bit
         pend_q <= (pend_q & ~clr_mask) | set_i;
         if (es_wr_i)
            en_q <= en_q | wmask_i;
         else if (ec_wr_i)
            en_q <= en_q & ~wmask_i;
         if (eoi_i)
            irq_q <= 1'b0;
         else
            irq_q <= |(pend_q & en_q);
      end
   end

   assign pend_o = pend_q;
   assign en_o   = en_q;
   assign irq_o  = irq_q;

   assert_set_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

   assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr_i |=> ((pend_q & $past(wmask_i) & ~$past(set_i)) == '0));

   assert_enable_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      es_wr_i |=> ((en_q & $past(wmask_i)) == $past(wmask_i)));

   assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_i |=> !irq_q);

   assert_line_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(|(pend_o & en_o)));

endmodule

// File: rtl/msi_group_ctrl.sv
module msi_group_ctrl
   import msi_grp_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int NUM_GRP = 8,
   parameter int GRP_BITS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               msg_valid,
   input  logic [DATA_W-1:0]  msg_data,
   output logic [NUM_GRP-1:0] irq_o
);

   localparam int NUM_VEC = NUM_GRP * GRP_BITS;
   localparam int GIDX_W  = $clog2(NUM_GRP);

   if (NUM_GRP < 2 || NUM_GRP > 16)
      $error("NUM_GRP must lie in 2..16");
   if (GRP_BITS < 1 || GRP_BITS > 4 || GRP_BITS > DATA_W)
      $error("GRP_BITS must lie in 1..4");
   if (OFS_GRP_BASE + GRP_STRIDE * NUM_GRP > (1 << ADDR_W))
      $error("ADDR_W too narrow for the group windows");

   logic                is_db;
   logic [NUM_GRP-1:0]  eoi_oh;
   logic [GIDX_W-1:0]   grp_idx;
   grp_reg_e            grp_kind;
   logic                bus_wr_ok;
   logic [NUM_VEC-1:0]  set_bus;
   logic [NUM_VEC-1:0]  set_msg;
   logic [GRP_BITS-1:0] pend_a [NUM_GRP];
   logic [GRP_BITS-1:0] en_a   [NUM_GRP];

   assign bus_wr_ok = bus_sel & bus_wr;

   msi_grp_decode #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .NUM_GRP(NUM_GRP)
   ) decode_i (
      .sel        (bus_sel),
      .wr         (bus_wr),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .is_doorbell(is_db),
      .eoi_oh     (eoi_oh),
      .grp_idx    (grp_idx),
      .grp_kind   (grp_kind)
   );

   msi_grp_vecdec #(
      .DATA_W  (DATA_W),
      .NUM_GRP (NUM_GRP),
      .GRP_BITS(GRP_BITS)
   ) vec_bus_i (
      .valid   (bus_wr_ok & is_db),
      .vec     (bus_wdata),
      .set_flat(set_bus)
   );

   msi_grp_vecdec #(
      .DATA_W  (DATA_W),
      .NUM_GRP (NUM_GRP),
      .GRP_BITS(GRP_BITS)
   ) vec_msg_i (
      .valid   (msg_valid),
      .vec     (msg_data),
      .set_flat(set_msg)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
      logic hit;
      assign hit = bus_wr_ok & (grp_idx == GIDX_W'(g));

      msi_grp_bank #(
         .GRP_BITS(GRP_BITS)
      ) bank_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_bus[g*GRP_BITS +: GRP_BITS] | set_msg[g*GRP_BITS +: GRP_BITS]),
         .st_wr_i(hit & (grp_kind == KIND_STAT)),
         .es_wr_i(hit & (grp_kind == KIND_ESET)),
         .ec_wr_i(hit & (grp_kind == KIND_ECLR)),
         .wmask_i(bus_wdata[GRP_BITS-1:0]),
         .eoi_i  (eoi_oh[g]),
         .pend_o (pend_a[g]),
         .en_o   (en_a[g]),
         .irq_o  (irq_o[g])
      );
   end

   always_comb begin
      unique case (grp_kind)
         KIND_STAT:            bus_rdata = DATA_W'(pend_a[grp_idx]);
         KIND_ESET, KIND_ECLR: bus_rdata = DATA_W'(en_a[grp_idx]);
         default:              bus_rdata = '0;
      endcase
   end

   assert_one_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eoi_oh));

   assert_vector_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_msg) && $onehot0(set_bus));

   assert_idle_lines_R1: assert property (@(posedge clk)
      !rst_n |=> (irq_o == '0));

endmodule

// File: tb/msi_group_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_group_ctrl_tb_top;

   localparam int NG = 8;
   localparam int GB = 4;
   localparam int AW = 12;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_sel, bus_wr, msg_valid;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata, msg_data;
   logic [NG-1:0] irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [GB-1:0] pm [NG];
   logic [GB-1:0] em [NG];

   always #2 clk = ~clk;

   msi_group_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .msg_valid(msg_valid), .msg_data(msg_data), .irq_o(irq_o)
   );

   function automatic logic [AW-1:0] st_a(int g); return AW'('h104 + 16 * g); endfunction
   function automatic logic [AW-1:0] es_a(int g); return AW'('h108 + 16 * g); endfunction
   function automatic logic [AW-1:0] ec_a(int g); return AW'('h10C + 16 * g); endfunction

   function automatic logic [NG-1:0] exp_irq();
      logic [NG-1:0] r;
      for (int g = 0; g < NG; g++) r[g] = |(pm[g] & em[g]);
      return r;
   endfunction

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic send_msg(logic [DW-1:0] v);
      @(negedge clk);
      msg_valid = 1'b1; msg_data = v;
      @(negedge clk);
      msg_valid = 1'b0;
   endtask

   task automatic clear_with_msg(logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      msg_valid = 1'b1; msg_data = v;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; msg_valid = 1'b0;
   endtask

   task automatic bus_read(logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic model_db(logic [DW-1:0] v);
      if (v < 32) pm[v % NG][v / NG] = 1'b1;
   endtask

   task automatic check_status(string req);
      logic [DW-1:0] d;
      for (int g = 0; g < NG; g++) begin
         bus_read(st_a(g), d);
         check(req, d, DW'(pm[g]));
      end
   endtask

   task automatic check_enables(string req);
      logic [DW-1:0] d;
      for (int g = 0; g < NG; g++) begin
         bus_read(es_a(g), d);
         check(req, d, DW'(em[g]));
         bus_read(ec_a(g), d);
         check(req, d, DW'(em[g]));
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [DW-1:0] d;
      rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
      bus_wdata = '0; msg_valid = 1'b0; msg_data = '0;
      for (int g = 0; g < NG; g++) begin pm[g] = '0; em[g] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 irq", DW'(irq_o), '0);
      check_status("R1 status");
      check_enables("R1 enable");

      // R2: sweep all vectors, alternating bus doorbell and message port
      for (int v = 0; v < 32; v++) begin
         if (v % 2 == 0) bus_write(AW'('h054), DW'(v));
         else send_msg(DW'(v));
         model_db(DW'(v));
         check_status("R2 placement");
         check("R7 no enable no line", DW'(irq_o), '0);
      end

      // R4: zero writes keep bits, partial mask clears only those bits
      for (int g = 0; g < NG; g++) begin
         bus_write(st_a(g), 32'h0);
         bus_write(st_a(g), 32'h5);
         pm[g] = pm[g] & ~4'h5;
      end
      check_status("R4 partial clear");
      for (int g = 0; g < NG; g++) begin
         bus_write(st_a(g), 32'hFFFF_FFFF);
         pm[g] = '0;
      end
      check_status("R4 full clear");

      // R3: out-of-range doorbells on both paths
      foreach (d[i]) begin end
      for (int k = 0; k < 5; k++) begin
         logic [DW-1:0] bad;
         case (k)
            0: bad = 32;
            1: bad = 33;
            2: bad = 255;
            3: bad = 32'h8000_0000;
            default: bad = 32'hFFFF_FFFF;
         endcase
         bus_write(AW'('h054), bad);
         send_msg(bad);
      end
      check_status("R3 ignored");

      // R5 / R11: enable set and clear
      for (int g = 0; g < NG; g++) begin
         bus_write(es_a(g), DW'((g * 3 + 1) & 15));
         em[g] = GB'((g * 3 + 1) & 15);
      end
      check_enables("R5 set");
      for (int g = 0; g < NG; g++) begin
         bus_write(ec_a(g), 32'h3);
         em[g] = em[g] & ~4'h3;
         bus_write(es_a(g), 32'hFFFF_FFF0);
      end
      check_enables("R5 clear, R11 upper bits");
      for (int g = 0; g < NG; g++) begin
         bus_write(ec_a(g), 32'hF);
         em[g] = '0;
      end
      check_enables("R5 all clear");

      // R6: raw status while disabled
      bus_write(AW'('h054), 32'd10);
      model_db(32'd10);
      check_status("R6 raw status");
      @(negedge clk);
      check("R6 no line", DW'(irq_o), '0);

      // R7: enabling group 2 bit 1 raises line one cycle after the enable lands
      bus_write(es_a(2), 32'h2);
      em[2] = 4'h2;
      check("R7 not yet", DW'(irq_o), '0);
      @(negedge clk);
      check("R7 raised", DW'(irq_o), DW'(8'h04));

      // R8: acknowledge pulses line low for one cycle
      bus_write(AW'('h050), 32'd6);
      check("R8 low after ack", DW'(irq_o), '0);
      @(negedge clk);
      check("R8 reasserted", DW'(irq_o), DW'(8'h04));

      // R9: foreign or out-of-range codes
      for (int k = 0; k < 7; k++) begin
         logic [DW-1:0] c;
         case (k)
            0: c = 0;
            1: c = 1;
            2: c = 2;
            3: c = 3;
            4: c = 12;
            5: c = 7;
            default: c = 32'hFFFF_FFFF;
         endcase
         bus_write(AW'('h050), c);
         check("R9 ignored code", DW'(irq_o), DW'(8'h04));
      end

      // R8: nothing pending after clear, ack leaves line low; new doorbell raises it
      bus_write(st_a(2), 32'h2);
      pm[2] = '0;
      check("R7 line lags clear", DW'(irq_o), DW'(8'h04));
      @(negedge clk);
      check("R7 dropped", DW'(irq_o), '0);
      bus_write(AW'('h050), 32'd6);
      @(negedge clk);
      check("R8 stays low", DW'(irq_o), '0);
      send_msg(32'd10);
      model_db(32'd10);
      @(negedge clk);
      check("R7 raised again", DW'(irq_o), DW'(8'h04));

      // R7: all groups enabled, accumulate vectors
      for (int g = 0; g < NG; g++) begin
         bus_write(st_a(g), 32'hF);
         pm[g] = '0;
         bus_write(es_a(g), 32'hF);
         em[g] = 4'hF;
      end
      @(negedge clk);
      check("R7 cleared", DW'(irq_o), '0);
      for (int v = 31; v >= 0; v -= 3) begin
         send_msg(DW'(v));
         model_db(DW'(v));
         @(negedge clk);
         check("R7 group lines", DW'(irq_o), DW'(exp_irq()));
      end

      // R10: doorbell and clear collide
      bus_write(st_a(5), 32'hF);
      pm[5] = '0;
      send_msg(32'd5);
      model_db(32'd5);
      clear_with_msg(st_a(5), 32'h1, 32'd5);
      check_status("R10 same bit kept");
      clear_with_msg(st_a(5), 32'h1, 32'd13);
      pm[5] = 4'h2;
      check_status("R10 other bit cleared");

      // R11: unmapped addresses read zero
      bus_read(AW'('h100), d); check("R11 gap", d, '0);
      bus_read(AW'('h180), d); check("R11 past end", d, '0);
      bus_read(AW'('h050), d); check("R11 ack reg", d, '0);
      bus_read(AW'('h054), d); check("R11 doorbell reg", d, '0);
      bus_read(AW'('h106), d); check("R11 misaligned", d, '0);

      finish_run();
   end

endmodule